// File: doc/BRIEF.md
# Register Rename Stage with Atomic Group Allocation

This block renames a group of up to three decoded micro-ops in one cycle. Each source register is looked up in an alias table. The table says whether the newest value of that architectural register sits in a reorder-buffer entry or in the retired register file. Every micro-op in the group receives a reorder-buffer entry, and that entry's index becomes the rename tag for its destination. Each micro-op also takes a reservation-station slot. Loads additionally need a load-buffer slot, and stores need a store-buffer slot.

The group is taken as a whole or not at all. If any one of the four resource pools cannot serve every micro-op in the group, nothing is allocated and the alias table keeps its contents. The front end then presents the same group again in a later cycle.

Inside a group, a later micro-op that reads a register written by an earlier micro-op of the same group picks up the earlier one's fresh tag. Retirement releases the oldest reorder-buffer entry and turns back to the retired file any mapping that still names that entry. A flush returns every resource and clears every mapping.

Top module: `rename_alias_table`

## Requirements
- R1: A source tag is 0 when the register's value is in the retired file. Otherwise the tag is {1'b1, index}: the most significant bit set, and the low ROB_W bits holding the reorder-buffer index taken from the alias table.
- R2: Used slots receive consecutive reorder-buffer indices starting at the allocation pointer, in slot order (slot 0 first). Unused slots are skipped, and the index wraps from ROB_DEPTH-1 to 0.
- R3: A source of slot i that names the destination of a used, destination-enabled slot j<i takes the tag {1'b1, index of j}. When several such slots exist, the highest-numbered one wins.
- R4: accept_o is high only when at least one slot is used and the group's needs fit in the free counts. The group needs one reorder-buffer entry and one reservation-station entry per used slot, one load-buffer entry per load and one store-buffer entry per store. A rejected group allocates nothing and leaves the alias table unchanged.
- R5: Released reservation-station, load-buffer and store-buffer entries, and retired reorder-buffer entries, are counted as free from the next cycle on, not in the cycle of release.
- R6: Retirement frees the oldest entry. Mappings that name the retiring entry return to the retired file. A source looked up in the retiring cycle already gets tag 0. A destination written in that same cycle keeps its new mapping.
- R7: During flush no group is accepted. Afterwards all mappings are 0, all resources are free, and allocation restarts at index 0.
- R8: One cycle after acceptance, out_valid_o is high with the slot mask, the indices and the source tags of that group. After reset, out_valid_o is low and all mappings are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Discard all speculative state |
| slot_used_i | input | GROUP | Slot carries a micro-op |
| dst_en_i | input | GROUP | Slot writes a destination register |
| is_load_i | input | GROUP | Slot needs a load-buffer entry |
| is_store_i | input | GROUP | Slot needs a store-buffer entry |
| dst_i | input | GROUP x AREG_W | Destination architectural register |
| src_a_i | input | GROUP x AREG_W | First source register |
| src_b_i | input | GROUP x AREG_W | Second source register |
| accept_o | output | 1 | Group taken this cycle |
| retire_i | input | 1 | Oldest reorder-buffer entry retires |
| retire_idx_i | input | ROB_W | Index of the retiring entry |
| rs_release_i | input | SLOT_CW | Reservation-station entries released |
| lb_release_i | input | 1 | One load-buffer entry released |
| sb_release_i | input | 1 | One store-buffer entry released |
| out_valid_o | output | 1 | Renamed group present |
| out_used_o | output | GROUP | Slot mask of the renamed group |
| out_rob_o | output | GROUP x ROB_W | Allocated reorder-buffer indices |
| out_src_a_o | output | GROUP x TAG_W | First source tags |
| out_src_b_o | output | GROUP x TAG_W | Second source tags |

## Verification
The bench builds the block with eight architectural registers, a six-entry reorder buffer, four reservation-station slots and two slots each in the load and store buffers. With these sizes the allocation pointer wraps past a non-power-of-two depth within a few groups. The sizes also let each pool become the single limiting resource on its own. Release-timing and retirement cases, including a source read in the very cycle its producer retires, fall within a dozen cycles.

// File: rtl/rat_pkg.sv
package rat_pkg;
  localparam int DEF_GROUP    = 3;
  localparam int DEF_NUM_AREG = 24;  // integer, floating stack and temporaries
  localparam int DEF_ROB      = 40;
  localparam int DEF_RS       = 20;
  localparam int DEF_LB       = 16;
  localparam int DEF_SB       = 12;
endpackage

// File: rtl/rat_credit.sv
module rat_credit #(
  parameter int CAP = 20,
  parameter int STEP_W = 2,
  localparam int CNT_W = $clog2(CAP + 1)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              flush_i,
  input  logic [STEP_W-1:0] take_i,
  input  logic [STEP_W-1:0] give_i,
  output logic [CNT_W-1:0]  free_o
);
  logic [CNT_W-1:0] held_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || flush_i) held_q <= '0;
    else held_q <= CNT_W'(int'(held_q) + int'(take_i) - int'(give_i));
  end

  assign free_o = CNT_W'(CAP) - held_q;

  assert_no_underflow_R5: assert property (@(posedge clk_i) disable iff (rst_i || flush_i)
    int'(give_i) <= int'(held_q)) else $error("released more than held");
  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    int'(held_q) <= CAP) else $error("pool over capacity");
endmodule

// File: rtl/rat_map.sv
module rat_map #(
  parameter int NUM_AREG = 24,
  parameter int GROUP = 3,
  parameter int ROB_W = 6,
  localparam int AREG_W = $clog2(NUM_AREG),
  localparam int TAG_W = ROB_W + 1
) (
  input  logic                           clk_i,
  input  logic                           rst_i,
  input  logic                           flush_i,
  input  logic [GROUP-1:0][AREG_W-1:0]   rd_a_i,
  input  logic [GROUP-1:0][AREG_W-1:0]   rd_b_i,
  output logic [GROUP-1:0][TAG_W-1:0]    tag_a_o,
  output logic [GROUP-1:0][TAG_W-1:0]    tag_b_o,
  input  logic                           we_i,
  input  logic [GROUP-1:0]               wr_en_i,
  input  logic [GROUP-1:0][AREG_W-1:0]   wr_reg_i,
  input  logic [GROUP-1:0][ROB_W-1:0]    wr_idx_i,
  input  logic                           ret_v_i,
  input  logic [ROB_W-1:0]               ret_idx_i
);
  logic [TAG_W-1:0] map_q [NUM_AREG];
  logic [TAG_W-1:0] view  [NUM_AREG];

  // table contents as seen after this cycle's retirement
  always_comb begin
    for (int r = 0; r < NUM_AREG; r++) begin
      view[r] = map_q[r];
      if (ret_v_i && map_q[r][TAG_W-1] && map_q[r][ROB_W-1:0] == ret_idx_i) view[r] = '0;
    end
  end

  // lookup, then override by the latest earlier writer in the group
  always_comb begin
    for (int i = 0; i < GROUP; i++) begin
      tag_a_o[i] = view[rd_a_i[i]];
      tag_b_o[i] = view[rd_b_i[i]];
      for (int j = 0; j < i; j++) begin
        if (wr_en_i[j] && wr_reg_i[j] == rd_a_i[i]) tag_a_o[i] = {1'b1, wr_idx_i[j]};
        if (wr_en_i[j] && wr_reg_i[j] == rd_b_i[i]) tag_b_o[i] = {1'b1, wr_idx_i[j]};
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || flush_i) begin
      for (int r = 0; r < NUM_AREG; r++) map_q[r] <= '0;
    end else begin
      for (int r = 0; r < NUM_AREG; r++) map_q[r] <= view[r];
      if (we_i)
        for (int j = 0; j < GROUP; j++)
          if (wr_en_i[j]) map_q[wr_reg_i[j]] <= {1'b1, wr_idx_i[j]};
    end
  end

  assert_write_sticks_R6: assert property (@(posedge clk_i) disable iff (rst_i || flush_i)
    (we_i && wr_en_i[0] && !(GROUP > 1 && wr_en_i[GROUP-1] && wr_reg_i[GROUP-1] == wr_reg_i[0]))
    |=> map_q[$past(wr_reg_i[0])][TAG_W-1]) else $error("new mapping lost");
endmodule

// File: rtl/rename_alias_table.sv
module rename_alias_table
  import rat_pkg::*;
#(
  parameter int GROUP = DEF_GROUP,
  parameter int NUM_AREG = DEF_NUM_AREG,
  parameter int ROB_DEPTH = DEF_ROB,
  parameter int RS_DEPTH = DEF_RS,
  parameter int LB_DEPTH = DEF_LB,
  parameter int SB_DEPTH = DEF_SB,
  localparam int AREG_W = $clog2(NUM_AREG),
  localparam int ROB_W = $clog2(ROB_DEPTH),
  localparam int TAG_W = ROB_W + 1,
  localparam int SLOT_CW = $clog2(GROUP + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_i,
  input  logic                         flush_i,
  input  logic [GROUP-1:0]             slot_used_i,
  input  logic [GROUP-1:0]             dst_en_i,
  input  logic [GROUP-1:0]             is_load_i,
  input  logic [GROUP-1:0]             is_store_i,
  input  logic [GROUP-1:0][AREG_W-1:0] dst_i,
  input  logic [GROUP-1:0][AREG_W-1:0] src_a_i,
  input  logic [GROUP-1:0][AREG_W-1:0] src_b_i,
  output logic                         accept_o,
  input  logic                         retire_i,
  input  logic [ROB_W-1:0]             retire_idx_i,
  input  logic [SLOT_CW-1:0]           rs_release_i,
  input  logic                         lb_release_i,
  input  logic                         sb_release_i,
  output logic                         out_valid_o,
  output logic [GROUP-1:0]             out_used_o,
  output logic [GROUP-1:0][ROB_W-1:0]  out_rob_o,
  output logic [GROUP-1:0][TAG_W-1:0]  out_src_a_o,
  output logic [GROUP-1:0][TAG_W-1:0]  out_src_b_o
);
  localparam int ROB_CW = $clog2(ROB_DEPTH + 1);
  localparam int RS_CW  = $clog2(RS_DEPTH + 1);
  localparam int LB_CW  = $clog2(LB_DEPTH + 1);
  localparam int SB_CW  = $clog2(SB_DEPTH + 1);

  logic [SLOT_CW-1:0] n_ops, n_ld, n_st;
  logic [ROB_CW-1:0]  rob_free;
  logic [RS_CW-1:0]   rs_free;
  logic [LB_CW-1:0]   lb_free;
  logic [SB_CW-1:0]   sb_free;
  logic [ROB_W-1:0]   tail_q, head_q;
  logic [GROUP-1:0][ROB_W-1:0] slot_idx;
  logic [GROUP-1:0][TAG_W-1:0] tag_a, tag_b;
  logic [SLOT_CW-1:0] rob_take, rs_take, lb_take, sb_take;

  assign n_ops = SLOT_CW'($countones(slot_used_i));
  assign n_ld  = SLOT_CW'($countones(slot_used_i & is_load_i));
  assign n_st  = SLOT_CW'($countones(slot_used_i & is_store_i));

  assign accept_o = (|slot_used_i) && !flush_i
                 && int'(rob_free) >= int'(n_ops) && int'(rs_free) >= int'(n_ops)
                 && int'(lb_free) >= int'(n_ld) && int'(sb_free) >= int'(n_st);

  assign rob_take = accept_o ? n_ops : '0;
  assign rs_take  = accept_o ? n_ops : '0;
  assign lb_take  = accept_o ? n_ld : '0;
  assign sb_take  = accept_o ? n_st : '0;

  rat_credit #(.CAP(ROB_DEPTH), .STEP_W(SLOT_CW)) u_rob_cr (.clk_i, .rst_i, .flush_i,
    .take_i(rob_take), .give_i(SLOT_CW'(retire_i)), .free_o(rob_free));
  rat_credit #(.CAP(RS_DEPTH), .STEP_W(SLOT_CW)) u_rs_cr (.clk_i, .rst_i, .flush_i,
    .take_i(rs_take), .give_i(rs_release_i), .free_o(rs_free));
  rat_credit #(.CAP(LB_DEPTH), .STEP_W(SLOT_CW)) u_lb_cr (.clk_i, .rst_i, .flush_i,
    .take_i(lb_take), .give_i(SLOT_CW'(lb_release_i)), .free_o(lb_free));
  rat_credit #(.CAP(SB_DEPTH), .STEP_W(SLOT_CW)) u_sb_cr (.clk_i, .rst_i, .flush_i,
    .take_i(sb_take), .give_i(SLOT_CW'(sb_release_i)), .free_o(sb_free));

  // consecutive indices from the tail, skipping unused slots
  always_comb begin
    int p;
    int s;
    p = 0;
    for (int i = 0; i < GROUP; i++) begin
      s = int'(tail_q) + p;
      if (s >= ROB_DEPTH) s = s - ROB_DEPTH;
      slot_idx[i] = ROB_W'(s);
      if (slot_used_i[i]) p = p + 1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || flush_i) begin
      tail_q <= '0;
      head_q <= '0;
    end else begin
      if (accept_o)
        tail_q <= (int'(tail_q) + int'(n_ops) >= ROB_DEPTH)
                  ? ROB_W'(int'(tail_q) + int'(n_ops) - ROB_DEPTH)
                  : ROB_W'(int'(tail_q) + int'(n_ops));
      if (retire_i)
        head_q <= (int'(head_q) == ROB_DEPTH - 1) ? '0 : head_q + 1'b1;
    end
  end

  rat_map #(.NUM_AREG(NUM_AREG), .GROUP(GROUP), .ROB_W(ROB_W)) u_map (
    .clk_i, .rst_i, .flush_i,
    .rd_a_i(src_a_i), .rd_b_i(src_b_i), .tag_a_o(tag_a), .tag_b_o(tag_b),
    .we_i(accept_o), .wr_en_i(slot_used_i & dst_en_i), .wr_reg_i(dst_i), .wr_idx_i(slot_idx),
    .ret_v_i(retire_i), .ret_idx_i(retire_idx_i));

  always_ff @(posedge clk_i) begin
    if (rst_i) out_valid_o <= 1'b0;
    else out_valid_o <= accept_o;
  end

  always_ff @(posedge clk_i) begin
    if (accept_o) begin
      out_used_o  <= slot_used_i;
      out_rob_o   <= slot_idx;
      out_src_a_o <= tag_a;
      out_src_b_o <= tag_b;
    end
  end

  assert_retire_oldest_R6: assert property (@(posedge clk_i) disable iff (rst_i || flush_i)
    retire_i |-> (retire_idx_i == head_q && int'(rob_free) != ROB_DEPTH))
    else $error("retirement out of order or empty");
  assert_flush_blocks_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    flush_i |-> !accept_o) else $error("group taken during flush");
  assert_issue_next_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    accept_o |=> out_valid_o) else $error("accepted group not presented");
  assert_tail_range_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    int'(tail_q) < ROB_DEPTH) else $error("allocation pointer out of range");
endmodule

// File: tb/tb_rename_alias_table.sv
`timescale 1ns/1ps
module tb_rename_alias_table;
  localparam int PER = 20;

  typedef struct packed {
    logic [2:0] used, den;
    logic [2:0][2:0] dst, sa, sb;
    logic [2:0] ld, st;
    logic rv;
    logic [2:0] ridx;
    logic [1:0] rsr;
    logic acc;
    logic [2:0][2:0] rob;
    logic [2:0][3:0] esa, esb;
  } vec_t;

  // slot fields are written {slot2, slot1, slot0}
  localparam vec_t VECS [9] = '{
    '{3'b011, 3'b011, {3'd0,3'd2,3'd1}, {3'd0,3'd1,3'd2}, {3'd0,3'd2,3'd3}, 3'b000, 3'b000,
      1'b0, 3'd0, 2'd0, 1'b1, {3'd0,3'd1,3'd0}, {4'd0,4'd8,4'd0}, {4'd0,4'd0,4'd0}},
    '{3'b111, 3'b011, {3'd0,3'd1,3'd3}, {3'd1,3'd3,3'd1}, {3'd3,3'd5,3'd2}, 3'b010, 3'b100,
      1'b0, 3'd0, 2'd0, 1'b0, 9'd0, 12'd0, 12'd0},
    '{3'b111, 3'b011, {3'd0,3'd1,3'd3}, {3'd1,3'd3,3'd1}, {3'd3,3'd5,3'd2}, 3'b010, 3'b100,
      1'b0, 3'd0, 2'd2, 1'b0, 9'd0, 12'd0, 12'd0},
    '{3'b111, 3'b011, {3'd0,3'd1,3'd3}, {3'd1,3'd3,3'd1}, {3'd3,3'd5,3'd2}, 3'b010, 3'b100,
      1'b0, 3'd0, 2'd0, 1'b1, {3'd4,3'd3,3'd2}, {4'd11,4'd10,4'd8}, {4'd10,4'd0,4'd9}},
    '{3'b001, 3'b001, {3'd0,3'd0,3'd4}, {3'd0,3'd0,3'd1}, {3'd0,3'd0,3'd2}, 3'b000, 3'b000,
      1'b1, 3'd0, 2'd1, 1'b1, {3'd0,3'd0,3'd5}, {4'd0,4'd0,4'd11}, {4'd0,4'd0,4'd9}},
    '{3'b001, 3'b001, {3'd0,3'd0,3'd6}, {3'd0,3'd0,3'd2}, {3'd0,3'd0,3'd4}, 3'b000, 3'b000,
      1'b1, 3'd1, 2'd0, 1'b1, {3'd0,3'd0,3'd0}, {4'd0,4'd0,4'd0}, {4'd0,4'd0,4'd13}},
    '{3'b001, 3'b000, 9'd0, {3'd0,3'd0,3'd2}, {3'd0,3'd0,3'd6}, 3'b000, 3'b000,
      1'b0, 3'd0, 2'd0, 1'b0, 9'd0, 12'd0, 12'd0},
    '{3'b001, 3'b000, 9'd0, {3'd0,3'd0,3'd2}, {3'd0,3'd0,3'd6}, 3'b000, 3'b000,
      1'b0, 3'd0, 2'd1, 1'b0, 9'd0, 12'd0, 12'd0},
    '{3'b001, 3'b000, 9'd0, {3'd0,3'd0,3'd2}, {3'd0,3'd0,3'd6}, 3'b000, 3'b000,
      1'b0, 3'd0, 2'd0, 1'b1, {3'd0,3'd0,3'd1}, {4'd0,4'd0,4'd0}, {4'd0,4'd0,4'd8}}
  };

  logic clk = 1'b0, rst = 1'b1, flush = 1'b0;
  logic [2:0] used = '0, den = '0, ld = '0, st = '0;
  logic [2:0][2:0] dst = '0, sa = '0, sb = '0;
  logic acc, rv = 1'b0, lbr = 1'b0, sbr = 1'b0, ov;
  logic [2:0] ridx = '0, ou;
  logic [1:0] rsr = '0;
  logic [2:0][2:0] orob;
  logic [2:0][3:0] osa, osb;
  int checks = 0, errors = 0;

  always #(PER/2) clk = ~clk;

  rename_alias_table #(.GROUP(3), .NUM_AREG(8), .ROB_DEPTH(6), .RS_DEPTH(4),
    .LB_DEPTH(2), .SB_DEPTH(2)) dut (
    .clk_i(clk), .rst_i(rst), .flush_i(flush), .slot_used_i(used), .dst_en_i(den),
    .is_load_i(ld), .is_store_i(st), .dst_i(dst), .src_a_i(sa), .src_b_i(sb),
    .accept_o(acc), .retire_i(rv), .retire_idx_i(ridx), .rs_release_i(rsr),
    .lb_release_i(lbr), .sb_release_i(sbr), .out_valid_o(ov), .out_used_o(ou),
    .out_rob_o(orob), .out_src_a_o(osa), .out_src_b_o(osb));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input vec_t v, input logic fl, input string req);
    @(negedge clk);
    used = v.used; den = v.den; dst = v.dst; sa = v.sa; sb = v.sb; ld = v.ld; st = v.st;
    rv = v.rv; ridx = v.ridx; rsr = v.rsr; flush = fl;
    #1 chk({req, " accept"}, int'(acc), int'(v.acc));
    @(posedge clk); #1;
    used = '0; rv = 1'b0; rsr = '0; flush = 1'b0;
    chk({req, " R8 out_valid"}, int'(ov), int'(v.acc));
    if (v.acc) begin
      chk({req, " R8 mask"}, int'(ou), int'(v.used));
      for (int i = 0; i < 3; i++) if (v.used[i]) begin
        chk({req, " R2 index"}, int'(orob[i]), int'(v.rob[i]));
        chk({req, " R1/R3 src a"}, int'(osa[i]), int'(v.esa[i]));
        chk({req, " R1/R3 src b"}, int'(osb[i]), int'(v.esb[i]));
      end
    end
  endtask

  function automatic vec_t mk(input logic [2:0] u, de, input logic [2:0][2:0] d, a, b,
                              input logic [2:0] l, s, input logic r, input logic [2:0] ri,
                              input logic [1:0] rr, input logic ac, input logic [2:0][2:0] ro,
                              input logic [2:0][3:0] ea, eb);
    vec_t v;
    v = '{u, de, d, a, b, l, s, r, ri, rr, ac, ro, ea, eb};
    return v;
  endfunction

  task automatic do_flush();
    run(mk(3'b001, 3'b000, 9'd0, 9'd0, 9'd0, 3'b0, 3'b0, 1'b0, 3'd0, 2'd0, 1'b0,
           9'd0, 12'd0, 12'd0), 1'b1, "R7 flush cycle");
  endtask

  initial begin
    #(PER * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1 chk("R8 reset out_valid", int'(ov), 0);
    chk("R4 idle accept", int'(acc), 0);

    // R1 R2 R3 R4 R5 R6: table-driven walk
    for (int k = 0; k < 9; k++) run(VECS[k], 1'b0, $sformatf("vec%0d", k));

    // R7: flush returns everything; R3 latest earlier writer wins
    do_flush();
    run(mk(3'b111, 3'b111, {3'd0,3'd7,3'd7}, {3'd7,3'd7,3'd1}, {3'd4,3'd0,3'd6},
           3'b110, 3'b000, 1'b0, 3'd0, 2'd0, 1'b1, {3'd2,3'd1,3'd0},
           {4'd9,4'd8,4'd0}, {4'd0,4'd0,4'd0}), 1'b0, "R7 R3 after flush");

    // R4: store buffer alone limits
    do_flush();
    run(mk(3'b111, 3'b000, 9'd0, 9'd0, 9'd0, 3'b000, 3'b111, 1'b0, 3'd0, 2'd0, 1'b0,
           9'd0, 12'd0, 12'd0), 1'b0, "R4 three stores");
    run(mk(3'b111, 3'b000, 9'd0, 9'd0, 9'd0, 3'b000, 3'b011, 1'b0, 3'd0, 2'd0, 1'b1,
           {3'd2,3'd1,3'd0}, 12'd0, 12'd0), 1'b0, "R4 two stores");

    // R4: load buffer alone limits, rejected group leaves table untouched
    do_flush();
    run(mk(3'b111, 3'b001, {3'd0,3'd0,3'd5}, 9'd0, 9'd0, 3'b111, 3'b000, 1'b0, 3'd0, 2'd0,
           1'b0, 9'd0, 12'd0, 12'd0), 1'b0, "R4 three loads");
    run(mk(3'b111, 3'b001, {3'd0,3'd0,3'd5}, {3'd0,3'd0,3'd5}, 9'd0, 3'b101, 3'b000, 1'b0,
           3'd0, 2'd0, 1'b1, {3'd2,3'd1,3'd0}, 12'd0, 12'd0), 1'b0, "R4 table unchanged");

    // R6: write in the retiring cycle keeps its mapping
    run(mk(3'b001, 3'b001, {3'd0,3'd0,3'd5}, 9'd0, 9'd0, 3'b000, 3'b000, 1'b1, 3'd0, 2'd3,
           1'b1, {3'd0,3'd0,3'd3}, 12'd0, 12'd0), 1'b0, "R6 retire with write");
    run(mk(3'b001, 3'b000, 9'd0, {3'd0,3'd0,3'd5}, 9'd0, 3'b000, 3'b000, 1'b0, 3'd0, 2'd0,
           1'b1, {3'd0,3'd0,3'd4}, {4'd0,4'd0,4'd11}, 12'd0), 1'b0, "R6 mapping kept");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule